// File: doc/BRIEF.md
# Dual-Loop Phase Detector with Powerdown Gating and Lock Monitor

This block holds the digital side of two phase-locked loops, called channel 0 and channel 1. Each channel takes a one-cycle strobe from its divided reference and a one-cycle strobe from its divided feedback. A tri-state phase-frequency detector turns the two strobes into pump-up and pump-down controls and a pump-enable. A polarity bit suits the controls to a VCO whose frequency rises or falls with tuning voltage. The detector spans a phase error of up to one full cycle either way. When both detector flags are set, a programmable delay clears them, so a loop in lock still produces short pulses of equal width and never falls into a dead zone.

Each channel also holds a lock detector and a powerdown controller. The lock detector measures the width of every detector pulse. A request to power down can take effect at once, or it can wait until the pump is idle, so the loop does not jump in frequency. One registered monitor pin, driven by a 4-bit selector, shows either channel's lock indicator, a raw divider strobe, or the fast-lock switch. The same selector can also hold the counters of either channel or of both. The analog charge pump and the loop filter sit outside this block.

Top module: `pfdl_top`

## Requirements
- R1: When the polarity bit is 1, a reference strobe with no feedback pending raises `pump_up` in the next cycle. `pump_up` stays high until the flags clear. A lone feedback strobe raises `pump_dn` in the same way.
- R2: Once both detector flags are high, both clear after exactly `RST_DLY` cycles. A locked loop therefore shows up and down pulses that are both `RST_DLY` cycles wide.
- R3: When the polarity bit is 0, `pump_up` and `pump_dn` swap: the feedback flag drives `pump_up` and the reference flag drives `pump_dn`.
- R4: `pump_en` is high exactly when a detector flag is set and the channel is neither tri-stated nor held. `pump_up` and `pump_dn` are low whenever `pump_en` is low. A channel that is idle and receives no strobe stays disabled in the next cycle.
- R5: When `tri_req` is high, `pump_en` is low, but the detector and the lock detector keep running.
- R6: When `pd_req` is high and `tri_req` is low, `pwrdn` rises only in a cycle where both detector flags are low. From then on it stays high while `pd_req` stays high.
- R7: When `pd_req` and `tri_req` are both high, `pwrdn` is high in the same cycle.
- R8: When `pd_req` is low, `pwrdn` is low in the same cycle. The detector resumes on the next strobe.
- R9: While a channel is powered down or its counters are reset, `div_hold` is high and `pump_en` is low. Its flags, its width and good-pulse counters, and its `locked` output are cleared at the next edge.
- R10: `locked` rises after `LOCK_CNT` consecutive detector pulses, each shorter than `WIDTH_THR` cycles. It falls in the cycle after any pulse reaches `WIDTH_THR` cycles.
- R11: The lock indicator of a channel is `locked` ANDed with "no flag set", so it is high with brief low pulses. Monitor codes: 1 selects the indicator of channel 0, 2 selects channel 1, and 3 selects the AND of both.
- R12: `mon_out` is registered and shows, one cycle later, the value its code selects. Codes 4 and 5 select the reference strobe of channel 0 and channel 1. Codes 6 and 7 select the feedback strobe of channel 0 and channel 1. Code 8 selects `fast_cur`, the fast-lock switch. Code 0 and every code from 9 to 15 drive the pin low.
- R13: Monitor code 9 resets the counters of channel 0, code 10 those of channel 1, and code 11 those of both. Under a counter reset, `div_hold` is high and the pump is tri-stated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Comparison clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_evt | input | 2 | Divided reference strobe, one bit per channel |
| fb_evt | input | 2 | Divided feedback strobe, one bit per channel |
| pol_pos | input | 2 | 1 means positive VCO slope |
| tri_req | input | 2 | Tri-state the pump; also selects immediate powerdown |
| pd_req | input | 2 | Powerdown request |
| fast_cur | input | 1 | High-current (fast-lock) bit shown by monitor code 8 |
| mon_sel | input | 4 | Monitor and counter-reset selector |
| pump_up | output | 2 | Pump-up control |
| pump_dn | output | 2 | Pump-down control |
| pump_en | output | 2 | Pump enable; low means high impedance |
| div_hold | output | 2 | Hold the external dividers at their load state |
| pwrdn | output | 2 | Channel is powered down |
| locked | output | 2 | Lock flag per channel |
| mon_out | output | 1 | Registered multiplexed monitor pin |

## Verification
The bench builds the block with `RST_DLY` = 2, `WIDTH_THR` = 4 and `LOCK_CNT` = 3. These values exercise the delay counter of the flag-clearing path rather than its one-cycle shortcut. They also make the good-versus-wide boundary only one cycle of phase offset wide: a feedback strobe one cycle early gives a 3-cycle pulse that counts toward lock, while two cycles early gives a 4-cycle pulse that drops lock. With the short lock count, lock, unlock and relock all happen within a few hundred cycles, and so do both powerdown timings and every monitor code, before a long run of random strobes.

// File: rtl/pfdl_pkg.sv
package pfdl_pkg;

  localparam int NCH = 2;

  typedef enum logic [3:0] {
    MON_OFF    = 4'd0,
    MON_LK0    = 4'd1,
    MON_LK1    = 4'd2,
    MON_LKALL  = 4'd3,
    MON_REF0   = 4'd4,
    MON_REF1   = 4'd5,
    MON_FB0    = 4'd6,
    MON_FB1    = 4'd7,
    MON_FAST   = 4'd8,
    MON_RST0   = 4'd9,
    MON_RST1   = 4'd10,
    MON_RSTALL = 4'd11
  } mon_sel_e;

endpackage

// File: rtl/pfdl_core.sv
module pfdl_core #(
  parameter int RST_DLY = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_evt,
  input  logic fb_evt,
  input  logic hold,
  output logic up_q,
  output logic dn_q
);

  localparam int BW = $clog2(RST_DLY + 1);
  localparam logic [BW-1:0] BLAST = BW'(RST_DLY - 1);

  logic [BW-1:0] bc_q, bc_d;
  logic          up_d, dn_d, clr;

  always_comb begin
    clr = up_q & dn_q & (bc_q == BLAST);
    if (hold) begin
      up_d = 1'b0;
      dn_d = 1'b0;
      bc_d = '0;
    end else begin
      up_d = clr ? ref_evt : (up_q | ref_evt);
      dn_d = clr ? fb_evt  : (dn_q | fb_evt);
      bc_d = (up_q & dn_q & ~clr) ? bc_q + 1'b1 : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
      bc_q <= '0;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
      bc_q <= bc_d;
    end
  end

  // R2: the overlap ends after the programmed delay
  p_clear_after_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && dn_q && bc_q == BLAST && !hold && !(ref_evt && fb_evt)) |=> !(up_q && dn_q));

  // R2: the overlap is not cut short
  p_overlap_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && dn_q && bc_q != BLAST && !hold) |=> (up_q && dn_q));

  // R9: a hold clears both flags
  p_hold_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!up_q && !dn_q));

endmodule

// File: rtl/pfdl_lock.sv
module pfdl_lock #(
  parameter int WIDTH_THR = 3,
  parameter int LOCK_CNT  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic hold,
  output logic lk_q,
  output logic ld
);

  localparam int WW = $clog2(WIDTH_THR + 1);
  localparam int GW = $clog2(LOCK_CNT + 1);
  localparam logic [WW-1:0] WSAT  = WW'(WIDTH_THR);
  localparam logic [WW-1:0] WLAST = WW'(WIDTH_THR - 1);
  localparam logic [GW-1:0] GSAT  = GW'(LOCK_CNT);
  localparam logic [GW-1:0] GLAST = GW'(LOCK_CNT - 1);

  logic [WW-1:0] wcnt_q, wcnt_d;
  logic [GW-1:0] gcnt_q, gcnt_d;
  logic          lk_d, wide, good;

  always_comb begin
    wide = active & (wcnt_q >= WLAST);
    good = ~active & (wcnt_q != '0) & (wcnt_q < WSAT);
    wcnt_d = '0;
    gcnt_d = gcnt_q;
    lk_d   = lk_q;
    if (hold) begin
      gcnt_d = '0;
      lk_d   = 1'b0;
    end else begin
      if (active) begin
        wcnt_d = (wcnt_q == WSAT) ? wcnt_q : wcnt_q + 1'b1;
      end
      if (wide) begin
        gcnt_d = '0;
        lk_d   = 1'b0;
      end else if (good) begin
        gcnt_d = (gcnt_q == GSAT) ? gcnt_q : gcnt_q + 1'b1;
        if (gcnt_q >= GLAST) begin
          lk_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      gcnt_q <= '0;
      lk_q   <= 1'b0;
    end else begin
      wcnt_q <= wcnt_d;
      gcnt_q <= gcnt_d;
      lk_q   <= lk_d;
    end
  end

  assign ld = lk_q & ~active;

  // R10: lock rises only on the final good pulse of a full run
  p_lock_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lk_q) |-> ($past(gcnt_q) == GLAST));

  // R10: a wide pulse drops lock
  p_wide_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wide |=> !lk_q);

endmodule

// File: rtl/pfdl_pwr.sv
module pfdl_pwr (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req,
  input  logic tri_req,
  input  logic active,
  output logic pwrdn
);

  logic pd_q;

  assign pwrdn = pd_req & (tri_req | pd_q | ~active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q <= 1'b0;
    end else begin
      pd_q <= pwrdn;
    end
  end

  // R6: a synchronous powerdown starts only while the pump is idle
  p_sync_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwrdn) && !tri_req) |-> !active);

  // R7: an immediate powerdown acts in the same cycle
  p_async_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_req && tri_req) |-> pwrdn);

  // R8: withdrawing the request releases at once
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_req) |-> !pwrdn);

endmodule

// File: rtl/pfdl_mux.sv
module pfdl_mux
  import pfdl_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     sel,
  input  logic [NCH-1:0] ld,
  input  logic [NCH-1:0] ref_evt,
  input  logic [NCH-1:0] fb_evt,
  input  logic           fast_cur,
  output logic [NCH-1:0] cnt_rst,
  output logic           mon_q
);

  logic mon_d;

  always_comb begin
    cnt_rst[0] = (sel == MON_RST0) || (sel == MON_RSTALL);
    cnt_rst[1] = (sel == MON_RST1) || (sel == MON_RSTALL);
    case (sel)
      MON_LK0:   mon_d = ld[0];
      MON_LK1:   mon_d = ld[1];
      MON_LKALL: mon_d = ld[0] & ld[1];
      MON_REF0:  mon_d = ref_evt[0];
      MON_REF1:  mon_d = ref_evt[1];
      MON_FB0:   mon_d = fb_evt[0];
      MON_FB1:   mon_d = fb_evt[1];
      MON_FAST:  mon_d = fast_cur;
      default:   mon_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_q <= 1'b0;
    end else begin
      mon_q <= mon_d;
    end
  end

  // R12: disabled output is driven low
  p_off_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel) == MON_OFF) |-> !mon_q);

  // R12: fast-lock code follows the high-current bit one cycle later
  p_fast_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel) == MON_FAST) |-> (mon_q == $past(fast_cur)));

endmodule

// File: rtl/pfdl_top.sv
module pfdl_top
  import pfdl_pkg::*;
#(
  parameter int RST_DLY   = 1,
  parameter int WIDTH_THR = 3,
  parameter int LOCK_CNT  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ref_evt,
  input  logic [NCH-1:0] fb_evt,
  input  logic [NCH-1:0] pol_pos,
  input  logic [NCH-1:0] tri_req,
  input  logic [NCH-1:0] pd_req,
  input  logic           fast_cur,
  input  logic [3:0]     mon_sel,
  output logic [NCH-1:0] pump_up,
  output logic [NCH-1:0] pump_dn,
  output logic [NCH-1:0] pump_en,
  output logic [NCH-1:0] div_hold,
  output logic [NCH-1:0] pwrdn,
  output logic [NCH-1:0] locked,
  output logic           mon_out
);

  logic [NCH-1:0] up_q, dn_q, active, hold, ld, cnt_rst;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign active[c] = up_q[c] | dn_q[c];
    assign hold[c]   = pwrdn[c] | cnt_rst[c];

    pfdl_core #(.RST_DLY(RST_DLY)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .ref_evt (ref_evt[c]),
      .fb_evt  (fb_evt[c]),
      .hold    (hold[c]),
      .up_q    (up_q[c]),
      .dn_q    (dn_q[c])
    );

    pfdl_lock #(.WIDTH_THR(WIDTH_THR), .LOCK_CNT(LOCK_CNT)) u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active[c]),
      .hold   (hold[c]),
      .lk_q   (locked[c]),
      .ld     (ld[c])
    );

    pfdl_pwr u_pwr (
      .clk     (clk),
      .rst_n   (rst_n),
      .pd_req  (pd_req[c]),
      .tri_req (tri_req[c]),
      .active  (active[c]),
      .pwrdn   (pwrdn[c])
    );

    always_comb begin
      pump_en[c]  = active[c] & ~tri_req[c] & ~hold[c];
      pump_up[c]  = pump_en[c] & (pol_pos[c] ? up_q[c] : dn_q[c]);
      pump_dn[c]  = pump_en[c] & (pol_pos[c] ? dn_q[c] : up_q[c]);
      div_hold[c] = hold[c];
    end

    // R4: an idle channel without strobes stays disabled
    p_idle_stays_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!active[c] && !ref_evt[c] && !fb_evt[c]) |=> !pump_en[c]);

    // R5: a tri-stated pump never drives
    p_tri_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tri_req[c] |-> (!pump_up[c] && !pump_dn[c]));
  end

  pfdl_mux u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (mon_sel),
    .ld       (ld),
    .ref_evt  (ref_evt),
    .fb_evt   (fb_evt),
    .fast_cur (fast_cur),
    .cnt_rst  (cnt_rst),
    .mon_q    (mon_out)
  );

endmodule

// File: tb/tb_pfdl_top.sv
module tb_pfdl_top;

  localparam int RST = 2;
  localparam int THR = 4;
  localparam int LCN = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] ref_evt, fb_evt, pol_pos, tri_req, pd_req;
  logic       fast_cur;
  logic [3:0] mon_sel;
  logic [1:0] pump_up, pump_dn, pump_en, div_hold, pwrdn, locked;
  logic       mon_out;

  int checks = 0;
  int errors = 0;

  // stimulus generator settings
  int per [2];
  int off [2];
  bit gen_en [2];
  bit rnd_en = 1'b0;
  int cyc = 0;

  // reference model state
  int m_up [2], m_dn [2], m_bc [2], m_w [2], m_g [2], m_lk [2], m_pd [2];
  int n_up [2], n_dn [2], n_bc [2], n_w [2], n_g [2], n_lk [2], n_pd [2];
  int m_mon, n_mon;

  always #4 clk = ~clk;

  pfdl_top #(.RST_DLY(RST), .WIDTH_THR(THR), .LOCK_CNT(LCN)) dut (
    .clk(clk), .rst_n(rst_n), .ref_evt(ref_evt), .fb_evt(fb_evt),
    .pol_pos(pol_pos), .tri_req(tri_req), .pd_req(pd_req),
    .fast_cur(fast_cur), .mon_sel(mon_sel), .pump_up(pump_up),
    .pump_dn(pump_dn), .pump_en(pump_en), .div_hold(div_hold),
    .pwrdn(pwrdn), .locked(locked), .mon_out(mon_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_up[c] = 0; m_dn[c] = 0; m_bc[c] = 0; m_w[c] = 0;
      m_g[c] = 0; m_lk[c] = 0; m_pd[c] = 0;
    end
    m_mon = 0;
  endtask

  // strobe generator
  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int c = 0; c < 2; c++) begin
      if (rnd_en) begin
        ref_evt[c] <= ($urandom % 6) == 0;
        fb_evt[c]  <= ($urandom % 6) == 0;
      end else begin
        ref_evt[c] <= gen_en[c] && ((cyc % per[c]) == 0);
        fb_evt[c]  <= gen_en[c] && ((cyc % per[c]) == off[c]);
      end
    end
  end

  // cycle-by-cycle comparison with the behavioural model
  initial begin
    model_reset();
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        int e_up, e_dn, e_en, e_hold, e_pwr, act, crst, clr, ld0, ld1, s;
        s = mon_sel;
        for (int c = 0; c < 2; c++) begin
          act   = m_up[c] | m_dn[c];
          crst  = (c == 0) ? (s == 9 || s == 11) : (s == 10 || s == 11);
          e_pwr = pd_req[c] && (tri_req[c] || m_pd[c] != 0 || act == 0);
          e_hold = e_pwr | crst;
          e_en  = act && !tri_req[c] && !e_hold;
          e_up  = e_en && (pol_pos[c] ? m_up[c] : m_dn[c]);
          e_dn  = e_en && (pol_pos[c] ? m_dn[c] : m_up[c]);
          chk(pump_en[c] == e_en, "R4 R5 pump_en", pump_en[c], e_en);
          chk(pump_up[c] == e_up, "R1 R2 R3 pump_up", pump_up[c], e_up);
          chk(pump_dn[c] == e_dn, "R1 R2 R3 pump_dn", pump_dn[c], e_dn);
          chk(pwrdn[c] == e_pwr, "R6 R7 R8 pwrdn", pwrdn[c], e_pwr);
          chk(div_hold[c] == e_hold, "R9 R13 div_hold", div_hold[c], e_hold);
          chk(locked[c] == m_lk[c], "R10 locked", locked[c], m_lk[c]);
          n_pd[c] = e_pwr;
          n_up[c] = m_up[c]; n_dn[c] = m_dn[c]; n_bc[c] = m_bc[c];
          n_w[c] = m_w[c]; n_g[c] = m_g[c]; n_lk[c] = m_lk[c];
          if (e_hold) begin
            n_up[c] = 0; n_dn[c] = 0; n_bc[c] = 0; n_w[c] = 0; n_g[c] = 0; n_lk[c] = 0;
          end else begin
            clr = m_up[c] && m_dn[c] && (m_bc[c] == RST - 1);
            n_up[c] = clr ? ref_evt[c] : (m_up[c] | ref_evt[c]);
            n_dn[c] = clr ? fb_evt[c] : (m_dn[c] | fb_evt[c]);
            n_bc[c] = (m_up[c] && m_dn[c] && !clr) ? m_bc[c] + 1 : 0;
            n_w[c]  = act ? ((m_w[c] + 1 > THR) ? THR : m_w[c] + 1) : 0;
            if (act && m_w[c] + 1 >= THR) begin
              n_g[c] = 0; n_lk[c] = 0;
            end else if (!act && m_w[c] != 0 && m_w[c] < THR) begin
              n_g[c] = (m_g[c] + 1 > LCN) ? LCN : m_g[c] + 1;
              if (m_g[c] + 1 >= LCN) n_lk[c] = 1;
            end
          end
        end
        chk(mon_out == m_mon[0], "R11 R12 mon_out", mon_out, m_mon);
        ld0 = m_lk[0] && !(m_up[0] || m_dn[0]);
        ld1 = m_lk[1] && !(m_up[1] || m_dn[1]);
        case (s)
          1: n_mon = ld0;
          2: n_mon = ld1;
          3: n_mon = ld0 && ld1;
          4: n_mon = ref_evt[0];
          5: n_mon = ref_evt[1];
          6: n_mon = fb_evt[0];
          7: n_mon = fb_evt[1];
          8: n_mon = fast_cur;
          default: n_mon = 0;
        endcase
      end
      @(posedge clk);
      #1;
      if (!rst_n) begin
        model_reset();
      end else begin
        for (int c = 0; c < 2; c++) begin
          m_up[c] = n_up[c]; m_dn[c] = n_dn[c]; m_bc[c] = n_bc[c];
          m_w[c] = n_w[c]; m_g[c] = n_g[c]; m_lk[c] = n_lk[c]; m_pd[c] = n_pd[c];
        end
        m_mon = n_mon;
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // watchdog
  initial begin
    repeat (40000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pol_pos = 2'b11; tri_req = 2'b00; pd_req = 2'b00;
    fast_cur = 1'b0; mon_sel = 4'd0;
    per[0] = 12; per[1] = 16; off[0] = 0; off[1] = 1;
    gen_en[0] = 1'b0; gen_en[1] = 1'b0;
    wait_cyc(3);
    #1;
    chk(pump_en == 2'b00, "R4 reset pump_en", pump_en, 0);
    chk(pwrdn == 2'b00, "R8 reset pwrdn", pwrdn, 0);
    chk(locked == 2'b00, "R10 reset locked", locked, 0);
    chk(mon_out == 1'b0, "R12 reset mon_out", mon_out, 0);
    chk(div_hold == 2'b00, "R9 reset div_hold", div_hold, 0);
    @(negedge clk);
    rst_n = 1'b1;
    gen_en[0] = 1'b1; gen_en[1] = 1'b1;
    mon_sel = 4'd1;
    wait_cyc(80);
    #3;
    chk(locked[0] == 1'b1, "R10 in-phase lock", locked[0], 1);
    // feedback four cycles late: wide pulses
    @(negedge clk); off[0] = 4;
    wait_cyc(40);
    #3;
    chk(locked[0] == 1'b0, "R10 wide pulse unlock", locked[0], 0);
    // feedback one cycle early: narrow, relock
    @(negedge clk); off[0] = 11;
    wait_cyc(60);
    #3;
    chk(locked[0] == 1'b1, "R10 relock", locked[0], 1);
    @(negedge clk); pol_pos[1] = 1'b0; mon_sel = 4'd3; off[1] = 5;
    wait_cyc(60);
    @(negedge clk); off[1] = 1; tri_req[0] = 1'b1;
    wait_cyc(30);
    @(negedge clk); tri_req[0] = 1'b0; pd_req[1] = 1'b1;
    wait_cyc(30);
    @(negedge clk); pd_req[1] = 1'b0;
    wait_cyc(30);
    @(negedge clk); tri_req[1] = 1'b1; pd_req[1] = 1'b1;
    #3;
    chk(pwrdn[1] == 1'b1, "R7 immediate powerdown", pwrdn[1], 1);
    wait_cyc(20);
    @(negedge clk); pd_req[1] = 1'b0; tri_req[1] = 1'b0;
    #3;
    chk(pwrdn[1] == 1'b0, "R8 release", pwrdn[1], 0);
    for (int s = 0; s < 16; s++) begin
      @(negedge clk); mon_sel = 4'(s); fast_cur = s[0];
      wait_cyc(12);
      @(negedge clk); fast_cur = ~fast_cur;
      wait_cyc(12);
    end
    @(negedge clk); rnd_en = 1'b1; mon_sel = 4'd1;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      pol_pos  = 2'($urandom);
      tri_req  = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
      pd_req   = (($urandom % 5) == 0) ? 2'($urandom) : 2'b00;
      mon_sel  = 4'($urandom % 12);
      fast_cur = 1'($urandom);
      wait_cyc(6);
    end
    @(negedge clk); rnd_en = 1'b0; pd_req = 2'b00; tri_req = 2'b00;
    wait_cyc(5);
    summary();
    $finish;
  end

endmodule